// File: doc/BRIEF.md
# Masked-Write Dual-Bank GPIO Controller

This peripheral drives 32 general-purpose pins, arranged as two banks of 16. Each bank has two registers. The output register holds the levels to drive, and the direction register holds one output enable per pin. A fifth register is read-only and returns the pin levels after synchronization. Software uses a simple register bus: a word address, a write strobe, 32 bits of write data and 32 bits of combinational read data.

A write to a bank register does not replace the whole register. The upper half-word of the write data is a per-bit enable, and the lower half-word gives the new values. Only the enabled bits take the new values. Two software agents can therefore change different pins in the same bank without a read-modify-write sequence. The direction bits drive the pin output enables directly. The output bits drive the pin levels directly.

Top module: `masked_gpio`

## Requirements
- R1: After reset every output bit and every direction bit is 0, so `pin_out` and `pin_oe` are all zero.
- R2: A write to word address 0 (low-bank output) updates `pin_out[i]` for i in 0..15 to `bus_wdata[i]` only where `bus_wdata[16+i]` is 1. The change is visible after the next rising clock edge.
- R3: A write to word address 2 (high-bank output) applies the same masked rule to `pin_out[16+i]`, with enable `bus_wdata[16+i]` and value `bus_wdata[i]`.
- R4: Writes to word address 1 (low-bank direction) and word address 3 (high-bank direction) use the same masked rule on the direction bits. `pin_oe` equals the direction bits, where 1 means drive.
- R5: Any bit whose enable is 0 keeps its previous value. A write with an all-zero enable half changes nothing.
- R6: Reading addresses 0 to 3 returns that register's 16-bit value in `bus_rdata[15:0]` and zeros in `bus_rdata[31:16]`. The read is combinational on `bus_addr`.
- R7: Reading word address 4 returns `pin_in` through a two-flop synchronizer. A pin level sampled at one rising edge appears on the read port after the following rising edge.
- R8: Writes to word address 4, or to any address above 4, change no register. Reads from addresses above 4 return zero.
- R9: A write to one bank's register leaves the other bank and the other register kind unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data: enable in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Driven pin levels |
| pin_oe | output | 32 | Per-pin output enable, 1 = drive |

## Verification
A corrupted output or direction bit shows up at once on `pin_out` or `pin_oe`, in the cycle after the faulty write. The bench compares both buses on every clock, so a wrong bit is caught within one cycle. A mask applied to the wrong half, or a write decoded to the wrong bank, changes pins that the reference model holds constant. A synchronizer with the wrong depth shifts the input read by a cycle, which the per-cycle comparison of `bus_rdata` exposes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int BANK_W   = 16;
    localparam int NBANKS   = 2;
    localparam int PINS     = BANK_W * NBANKS;
    localparam int BUS_W    = 2 * BANK_W;
    localparam int NREGS    = 2 * NBANKS;
    localparam int ADDR_W   = 4;
    localparam logic [ADDR_W-1:0] ADDR_PINS = ADDR_W'(NREGS);

    typedef enum logic {KIND_OUT = 1'b0, KIND_DIR = 1'b1} reg_kind_e;
endpackage

// File: rtl/gpio_mreg.sv
module gpio_mreg #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2*W-1:0] wdata,
    output logic [W-1:0]   q
);
    typedef struct packed {
        logic [W-1:0] val;
    } state_t;

    state_t st_d, st_q;
    logic [W-1:0] en;
    logic [W-1:0] nv;

    always_comb begin
        en   = wdata[2*W-1:W];
        nv   = wdata[W-1:0];
        st_d = st_q;
        if (wr_en) st_d.val = (st_q.val & ~en) | (nv & en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.val;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q)); // R8
    AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q ^ $past(q)) & ~$past(wdata[2*W-1:W])) == '0); // R5
    AST_ENABLED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q ^ $past(wdata[W-1:0])) & $past(wdata[2*W-1:W])) == '0); // R2
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int k = 1; k < STAGES; k++) st_d.stg[k] = st_q.stg[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stg[STAGES-1];

    generate
        if (STAGES > 1) begin : g_chk
            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> dout == $past(st_q.stg[STAGES-2])); // R7
        end
    endgenerate
endmodule

// File: rtl/masked_gpio.sv
module masked_gpio
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    logic [NREGS-1:0][BANK_W-1:0] reg_q;
    logic [NREGS-1:0]             reg_wr;
    logic [PINS-1:0]              pins_sync;

    genvar gi;
    generate
        for (gi = 0; gi < NREGS; gi++) begin : g_reg
            assign reg_wr[gi] = bus_wr && (bus_addr == ADDR_W'(gi));
            gpio_mreg #(.W(BANK_W)) i_mreg (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (reg_wr[gi]),
                .wdata (bus_wdata),
                .q     (reg_q[gi])
            );
        end
        for (gi = 0; gi < NBANKS; gi++) begin : g_bank
            assign pin_out[gi*BANK_W +: BANK_W] = reg_q[2*gi + int'(KIND_OUT)];
            assign pin_oe [gi*BANK_W +: BANK_W] = reg_q[2*gi + int'(KIND_DIR)];
        end
    endgenerate

    gpio_sync #(.W(PINS), .STAGES(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pins_sync)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_PINS)
            bus_rdata = {{(BUS_W-BANK_W){1'b0}}, reg_q[bus_addr[$clog2(NREGS)-1:0]]};
        else if (bus_addr == ADDR_PINS)
            bus_rdata = pins_sync;
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < ADDR_PINS) |-> bus_rdata[BUS_W-1:BANK_W] == '0); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADDR_PINS) |-> bus_rdata == '0); // R8
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= ADDR_PINS) |=> $stable(pin_out) && $stable(pin_oe)); // R8
    AST_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1] == 1'b0) |=> $stable(pin_out[PINS-1:BANK_W])); // R9
endmodule

// File: tb/test_masked_gpio.sv
module test_masked_gpio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    logic [15:0] m_reg [4];
    logic [31:0] m_s1, m_s2;

    always #5 clk = ~clk;

    masked_gpio i_masked_gpio (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) m_reg[k] = '0;
            m_s1 = '0; m_s2 = '0;
        end else begin
            if (bus_wr && bus_addr < 4)
                m_reg[bus_addr] = (m_reg[bus_addr] & ~bus_wdata[31:16]) |
                                  (bus_wdata[15:0] & bus_wdata[31:16]);
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        if (a < 4)  return {16'h0, m_reg[a]};
        if (a == 4) return m_s2;
        return 32'h0;
    endfunction

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic check_all();
        cmp("pin_out", pin_out, {m_reg[2], m_reg[0]});
        cmp("pin_oe", pin_oe, {m_reg[3], m_reg[1]});
        cmp("rdata", bus_rdata, exp_read(bus_addr));
    endtask

    task automatic step(input logic [3:0] a, input logic w, input logic [31:0] d, input logic [31:0] p);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; pin_in = p;
        #1 check_all();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #2000000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        #12;
        cmp("reset pin_out", pin_out, 32'h0);
        cmp("reset pin_oe", pin_oe, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 5; a++) step(a[3:0], 1'b0, '0, '0);

        // R2: low output bank masked writes
        cur_req = "R2";
        step(4'd0, 1'b1, 32'hFFFF_A5A5, 32'h0);
        step(4'd0, 1'b0, '0, 32'h0);
        step(4'd0, 1'b1, 32'h00F0_0F0F, 32'h0);
        step(4'd0, 1'b0, '0, 32'h0);

        // R3: high output bank
        cur_req = "R3";
        step(4'd2, 1'b1, 32'hF00F_1234, 32'h0);
        step(4'd2, 1'b0, '0, 32'h0);

        // R4: direction registers
        cur_req = "R4";
        step(4'd1, 1'b1, 32'h8001_FFFF, 32'h0);
        step(4'd3, 1'b1, 32'hFFFF_C3C3, 32'h0);
        step(4'd3, 1'b0, '0, 32'h0);

        // R5: zero enable changes nothing
        cur_req = "R5";
        for (int a = 0; a < 4; a++) step(a[3:0], 1'b1, 32'h0000_FFFF, 32'h0);
        step(4'd0, 1'b0, '0, 32'h0);

        // R6: readback upper half zero
        cur_req = "R6";
        for (int a = 0; a < 4; a++) step(a[3:0], 1'b0, '0, 32'h0);

        // R7: synchronizer latency
        cur_req = "R7";
        step(4'd4, 1'b0, '0, 32'hDEAD_BEEF);
        step(4'd4, 1'b0, '0, 32'h1234_5678);
        step(4'd4, 1'b0, '0, 32'h1234_5678);
        step(4'd4, 1'b0, '0, 32'h0);
        step(4'd4, 1'b0, '0, 32'h0);

        // R8: input and unmapped writes ignored, reads zero
        cur_req = "R8";
        step(4'd4, 1'b1, 32'hFFFF_FFFF, 32'h5555_AAAA);
        for (int a = 5; a < 16; a++) step(a[3:0], 1'b1, 32'hFFFF_FFFF, 32'h5555_AAAA);
        step(4'd9, 1'b0, '0, 32'h5555_AAAA);

        // R9: bank isolation under random traffic
        cur_req = "R9";
        for (int n = 0; n < 400; n++)
            step(4'($urandom_range(0, 6)), 1'($urandom), $urandom, $urandom);

        finish_run();
    end
endmodule